// File: doc/BRIEF.md
# Interrupt Entry Sequencer

This block performs the hardware side of taking an interrupt on a small 8-bit CPU. Each peripheral source presents a pending flag and a local enable. A source asks for service only when both are high. A global mask bit in the condition register can block every source. The block waits for the CPU to signal an instruction boundary. If a request is then pending and the mask is clear, the block saves the CPU context to a byte-wide stack in memory. It then fetches a two-byte service address for the most urgent pending source.

The context goes out over a byte memory bus as five consecutive writes. The stack pointer moves down by one after each write. The service address comes back as two consecutive reads from the vector slot of the winning source. When both bytes are in, the block pulses `done`. With that pulse it presents the new program counter, the condition register with the mask bit set, and the lowered stack pointer. The CPU loads these values and starts the handler.

Top module: `irq_entry_seq`

## Requirements
- R1: Source i requests service only when `src_flag[i]` and `src_en[i]` are both 1. A flag without its enable, or an enable without its flag, never starts a sequence.
- R2: No sequence starts while bit 3 of `ccr_in` (the mask bit) is 1.
- R3: A sequence starts only on a clock edge where `insn_boundary` is 1, the block is idle, and R1 and R2 allow it.
- R4: Five write cycles follow the start edge, one per cycle. They write PC bits 7:0 at `sp_in`, then PC bits 15:8 at `sp_in`-1, then X at `sp_in`-2, then A at `sp_in`-3, then the condition register at `sp_in`-4.
- R5: The stacked condition register equals `ccr_in` as sampled at the start edge, with its mask bit still 0. The `new_ccr` output is that value with bit 3 set to 1.
- R6: When several sources request at once, the lowest index wins.
- R7: The winner is fixed at the start edge. Flag or enable changes during the sequence do not change the vector that is fetched.
- R8: In the two cycles after the last write, the block reads the vector high byte at `VEC_BASE` - 2*index, then the low byte at the next higher address. Read data is valid on `mem_rdata` in the cycle after each read.
- R9: `done` is a one-cycle pulse, two cycles after the low-byte read. During the pulse, `new_pc` = {high byte, low byte} and `new_sp` = `sp_in` - 5.
- R10: `busy` is high from the cycle after the start edge until the cycle before `done`. While `busy` is 0 there is no bus access. A request that stays pending starts a new sequence only once the block is idle again.
- R11: After reset the outputs `busy`, `done`, `mem_we` and `mem_re` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| src_flag | input | NSRC | Pending flag of each source |
| src_en | input | NSRC | Local enable of each source |
| insn_boundary | input | 1 | The current instruction has completed |
| pc_in | input | 16 | Program counter to save |
| x_in | input | 8 | X register to save |
| a_in | input | 8 | Accumulator to save |
| ccr_in | input | 8 | Condition register; bit 3 is the global mask |
| sp_in | input | 16 | Stack pointer at entry |
| mem_addr | output | 16 | Memory address |
| mem_wdata | output | 8 | Memory write data |
| mem_rdata | input | 8 | Memory read data, valid the cycle after a read |
| mem_we | output | 1 | Write strobe |
| mem_re | output | 1 | Read strobe |
| busy | output | 1 | Entry sequence in progress |
| done | output | 1 | One-cycle pulse: the new state is valid |
| new_pc | output | 16 | Fetched service address |
| new_ccr | output | 8 | Saved condition register with the mask set |
| new_sp | output | 16 | Stack pointer after the five pushes |

## Verification
The bench offers half-formed requests: a flag without its enable, and an enable without its flag. A design that ANDed the pairs wrongly would start a sequence anyway. It also holds the mask set, and holds a request with the boundary low. A design that ignored either input would start early, and the cycle-by-cycle model would report the bus activity it did not expect.

Several sources request together to catch an inverted priority order. Higher-priority flags are raised in the middle of a sequence. A design that failed to latch the winner would then read the wrong vector slot. Sources 0 and NSRC-1 cover both ends of the vector table.

A request held high across several sequences tests the restart. A design that restarted while busy, or lost the idle cycle, would put the bus out of step with the model. Every write byte and address is compared, which catches a wrong push order, an off-by-one stack pointer, or the mask being set before the condition register is stacked.

// File: rtl/irq_seq_pkg.sv
package irq_seq_pkg;

  // sequencer phases
  typedef enum logic [2:0] {
    S_IDLE,
    S_PUSH,
    S_VHI,
    S_VLO,
    S_FIN
  } seq_state_e;

  localparam int PUSH_BYTES = 5;
  localparam int SLOT_W     = 3;

  // vector slot of a source: two bytes per source, counting down from the base
  function automatic logic [15:0] vec_addr_of(input logic [15:0] base,
                                              input int unsigned idx);
    return base - 16'(idx << 1);
  endfunction

  // byte placed on the stack in a given push slot
  function automatic logic [7:0] push_byte(input logic [SLOT_W-1:0] slot,
                                           input logic [15:0] pc,
                                           input logic [7:0]  x,
                                           input logic [7:0]  a,
                                           input logic [7:0]  ccr);
    case (slot)
      3'd0:    return pc[7:0];
      3'd1:    return pc[15:8];
      3'd2:    return x;
      3'd3:    return a;
      default: return ccr;
    endcase
  endfunction

  // condition register with the mask bit forced on
  function automatic logic [7:0] with_mask(input logic [7:0] c,
                                           input int unsigned pos);
    logic [7:0] r;
    r = c;
    r[pos[2:0]] = 1'b1;
    return r;
  endfunction

endpackage

// File: rtl/irq_pick.sv
module irq_pick #(
  parameter int NSRC = 8,
  localparam int IW = (NSRC > 1) ? $clog2(NSRC) : 1
) (
  input  logic [NSRC-1:0] src_flag,
  input  logic [NSRC-1:0] src_en,
  output logic            any_req,
  output logic [IW-1:0]   win_idx
);

  logic [NSRC-1:0] req;

  // a source asks only with both its flag and its enable
  for (genvar g = 0; g < NSRC; g++) begin : g_req
    assign req[g] = src_flag[g] & src_en[g];
  end

  // lowest index wins: scan from the top so the last hit is the lowest
  always_comb begin
    any_req = 1'b0;
    win_idx = '0;
    for (int i = NSRC - 1; i >= 0; i--) begin
      if (req[i]) begin
        any_req = 1'b1;
        win_idx = IW'(i);
      end
    end
  end

endmodule

// File: rtl/irq_ctx_push.sv
module irq_ctx_push
  import irq_seq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              capture,
  input  logic [15:0]       pc_in,
  input  logic [7:0]        x_in,
  input  logic [7:0]        a_in,
  input  logic [7:0]        ccr_in,
  input  logic [15:0]       sp_in,
  output logic              active,
  output logic [SLOT_W-1:0] slot,
  output logic              last,
  output logic [15:0]       addr,
  output logic [7:0]        data,
  output logic [15:0]       sp_now,
  output logic [7:0]        ccr_saved
);

  localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(PUSH_BYTES - 1);

  logic [15:0] pc_q;
  logic [7:0]  x_q, a_q;
  logic [15:0] sp_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active    <= 1'b0;
      slot      <= '0;
      pc_q      <= '0;
      x_q       <= '0;
      a_q       <= '0;
      ccr_saved <= '0;
      sp_q      <= '0;
    end else if (capture) begin
      active    <= 1'b1;
      slot      <= '0;
      pc_q      <= pc_in;
      x_q       <= x_in;
      a_q       <= a_in;
      ccr_saved <= ccr_in;
      sp_q      <= sp_in;
    end else if (active) begin
      // write at the pointer, then step it down
      sp_q <= sp_q - 16'd1;
      slot <= slot + 1'b1;
      if (slot == LAST_SLOT) active <= 1'b0;
    end
  end

  assign last   = active && (slot == LAST_SLOT);
  assign addr   = sp_q;
  assign data   = push_byte(slot, pc_q, x_q, a_q, ccr_saved);
  assign sp_now = sp_q;

endmodule

// File: rtl/irq_entry_seq.sv
module irq_entry_seq
  import irq_seq_pkg::*;
#(
  parameter int          NSRC     = 8,
  parameter logic [15:0] VEC_BASE = 16'hFFFE,
  parameter int          MASK_BIT = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] src_flag,
  input  logic [NSRC-1:0] src_en,
  input  logic            insn_boundary,
  input  logic [15:0]     pc_in,
  input  logic [7:0]      x_in,
  input  logic [7:0]      a_in,
  input  logic [7:0]      ccr_in,
  input  logic [15:0]     sp_in,
  output logic [15:0]     mem_addr,
  output logic [7:0]      mem_wdata,
  input  logic [7:0]      mem_rdata,
  output logic            mem_we,
  output logic            mem_re,
  output logic            busy,
  output logic            done,
  output logic [15:0]     new_pc,
  output logic [7:0]      new_ccr,
  output logic [15:0]     new_sp
);

  localparam int IW = (NSRC > 1) ? $clog2(NSRC) : 1;

  seq_state_e        state_q, state_d;
  logic              any_req;
  logic [IW-1:0]     win_idx, win_q;
  logic              start_ev;
  logic              push_active, push_last;
  logic [SLOT_W-1:0] push_slot;
  logic [15:0]       push_addr, sp_final, vec_addr;
  logic [7:0]        push_data, ccr_saved, vec_hi_q;
  logic [15:0]       pc_q;
  logic              done_q;

  irq_pick #(.NSRC(NSRC)) u_pick (
    .src_flag (src_flag),
    .src_en   (src_en),
    .any_req  (any_req),
    .win_idx  (win_idx)
  );

  // take the request only at a boundary, when idle and unmasked
  assign start_ev = (state_q == S_IDLE) && insn_boundary && any_req && !ccr_in[MASK_BIT];

  irq_ctx_push u_push (
    .clk       (clk),
    .rst_n     (rst_n),
    .capture   (start_ev),
    .pc_in     (pc_in),
    .x_in      (x_in),
    .a_in      (a_in),
    .ccr_in    (ccr_in),
    .sp_in     (sp_in),
    .active    (push_active),
    .slot      (push_slot),
    .last      (push_last),
    .addr      (push_addr),
    .data      (push_data),
    .sp_now    (sp_final),
    .ccr_saved (ccr_saved)
  );

  always_comb begin
    state_d = state_q;
    case (state_q)
      S_IDLE:  if (start_ev) state_d = S_PUSH;
      S_PUSH:  if (push_last) state_d = S_VHI;
      S_VHI:   state_d = S_VLO;
      S_VLO:   state_d = S_FIN;
      S_FIN:   state_d = S_IDLE;
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= S_IDLE;
      win_q    <= '0;
      vec_hi_q <= '0;
      pc_q     <= '0;
      done_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= 1'b0;
      // winner frozen here for the whole sequence
      if (start_ev) win_q <= win_idx;
      // high byte arrives during the low-byte read cycle
      if (state_q == S_VLO) vec_hi_q <= mem_rdata;
      if (state_q == S_FIN) begin
        pc_q   <= {vec_hi_q, mem_rdata};
        done_q <= 1'b1;
      end
    end
  end

  assign vec_addr  = vec_addr_of(VEC_BASE, 32'(win_q));
  assign mem_we    = push_active;
  assign mem_re    = (state_q == S_VHI) || (state_q == S_VLO);
  assign mem_addr  = push_active          ? push_addr :
                     (state_q == S_VLO)   ? vec_addr + 16'd1 : vec_addr;
  assign mem_wdata = push_active ? push_data : 8'h00;
  assign busy      = (state_q != S_IDLE);
  assign done      = done_q;
  assign new_pc    = pc_q;
  assign new_ccr   = with_mask(ccr_saved, MASK_BIT);
  assign new_sp    = sp_final;

  // ---- assertions ----
  AST_NEEDS_REQUEST: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(|(src_flag & src_en)));                            // R1
  AST_MASK_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> !$past(ccr_in[MASK_BIT]));                               // R2
  AST_NEEDS_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(insn_boundary));                                   // R3
  AST_STACK_STEPS_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we && $past(mem_we) |-> mem_addr == $past(mem_addr) - 16'd1);        // R4
  AST_CCR_STACKED_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we && push_slot == SLOT_W'(PUSH_BYTES - 1) |-> !mem_wdata[MASK_BIT]); // R5
  AST_NEW_CCR_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> new_ccr[MASK_BIT]);                                             // R5
  AST_WIN_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    busy && $past(busy) |-> $stable(win_q));                                 // R7
  AST_VEC_LO_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    mem_re && $past(mem_re) |-> mem_addr == $past(mem_addr) + 16'd1);        // R8
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);                                                         // R9
  AST_NO_BUS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mem_we && !mem_re);                                           // R10

endmodule

// File: tb/irq_entry_seq_test.sv
module irq_entry_seq_test;

  localparam int NSRC = 8;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [NSRC-1:0] src_flag = '0, src_en = '0;
  logic            insn_boundary = 1'b0;
  logic [15:0]     pc_in = '0, sp_in = '0;
  logic [7:0]      x_in = '0, a_in = '0, ccr_in = '0;
  logic [15:0]     mem_addr, new_pc, new_sp;
  logic [7:0]      mem_wdata, new_ccr;
  logic [7:0]      mem_rdata = '0;
  logic            mem_we, mem_re, busy, done;

  int total = 0, bad = 0, cycles = 0;
  string scen = "R11";

  always #4 clk = ~clk; // 125 MHz

  irq_entry_seq #(.NSRC(NSRC)) uut (
    .clk(clk), .rst_n(rst_n), .src_flag(src_flag), .src_en(src_en),
    .insn_boundary(insn_boundary), .pc_in(pc_in), .x_in(x_in), .a_in(a_in),
    .ccr_in(ccr_in), .sp_in(sp_in), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .mem_we(mem_we), .mem_re(mem_re), .busy(busy),
    .done(done), .new_pc(new_pc), .new_ccr(new_ccr), .new_sp(new_sp)
  );

  function automatic logic [7:0] rom_byte(input logic [15:0] a);
    return a[7:0] ^ a[15:8] ^ 8'h3C;
  endfunction

  // memory: read data one cycle after the strobe
  always @(posedge clk) if (mem_re) mem_rdata <= rom_byte(mem_addr);

  typedef struct {
    bit we, re, dn, bsy;
    int addr, wdata, pc, sp, ccr;
  } exp_t;

  exp_t q[$];
  exp_t cur;

  function automatic exp_t idle_e();
    exp_t e;
    e.we = 0; e.re = 0; e.dn = 0; e.bsy = 0;
    e.addr = 0; e.wdata = 0; e.pc = 0; e.sp = 0; e.ccr = 0;
    return e;
  endfunction

  // behavioural reference, advanced at every edge
  always @(posedge clk) begin
    cycles++;
    if (!rst_n) begin
      q.delete();
      cur = idle_e();
    end else begin
      if (q.size() == 0 && insn_boundary && ((src_flag & src_en) != 0) && !ccr_in[3]) begin
        int w = -1;
        int va;
        int bytes[5];
        exp_t e;
        for (int i = NSRC - 1; i >= 0; i--) if (src_flag[i] && src_en[i]) w = i;
        bytes[0] = pc_in[7:0]; bytes[1] = pc_in[15:8];
        bytes[2] = x_in; bytes[3] = a_in; bytes[4] = ccr_in;
        for (int k = 0; k < 5; k++) begin
          e = idle_e(); e.bsy = 1; e.we = 1;
          e.addr = (sp_in - k) & 16'hFFFF; e.wdata = bytes[k];
          q.push_back(e);
        end
        va = (16'hFFFE - 2 * w) & 16'hFFFF;
        e = idle_e(); e.bsy = 1; e.re = 1; e.addr = va; q.push_back(e);
        e = idle_e(); e.bsy = 1; e.re = 1; e.addr = va + 1; q.push_back(e);
        e = idle_e(); e.bsy = 1; q.push_back(e);
        e = idle_e(); e.dn = 1;
        e.pc  = {rom_byte(16'(va)), rom_byte(16'(va + 1))};
        e.sp  = (sp_in - 5) & 16'hFFFF;
        e.ccr = ccr_in | 8'h08;
        q.push_back(e);
      end
      cur = (q.size() != 0) ? q.pop_front() : idle_e();
    end
    if (cycles > 20000) begin
      bad++; total++;
      $display("FAIL watchdog: run hung act=%0d exp<=20000 cycles", cycles);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s (scenario %s) t=%0t act=%0h exp=%0h", req, scen, $time, act, exp);
    end
  endtask

  // compare against the model away from the edge
  always @(negedge clk) if (rst_n) begin
    chk("R10 busy", busy, cur.bsy);
    chk("R9 done", done, cur.dn);
    chk("R4 mem_we", mem_we, cur.we);
    chk("R8 mem_re", mem_re, cur.re);
    if (cur.we) begin
      chk("R4 push addr", mem_addr, cur.addr);
      chk("R4/R5 push data", mem_wdata, cur.wdata);
    end
    if (cur.re) chk("R8 vector addr", mem_addr, cur.addr);
    if (cur.dn) begin
      chk("R9 new_pc", new_pc, cur.pc);
      chk("R9 new_sp", new_sp, cur.sp);
      chk("R5 new_ccr", new_ccr, cur.ccr);
    end
  end

  task automatic drive(input logic [NSRC-1:0] f, input logic [NSRC-1:0] e,
                       input logic b, input logic [7:0] c);
    @(negedge clk);
    src_flag = f; src_en = e; insn_boundary = b; ccr_in = c;
    pc_in = pc_in + 16'h1357; x_in = x_in + 8'h11; a_in = a_in + 8'h23;
    sp_in = sp_in - 16'h0021;
  endtask

  task automatic settle(input int n);
    @(negedge clk);
    insn_boundary = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  initial begin
    pc_in = 16'h8123; sp_in = 16'h04FF; x_in = 8'h40; a_in = 8'h7E;
    repeat (3) @(negedge clk);
    // R11: reset values
    chk("R11 busy", busy, 0);
    chk("R11 done", done, 0);
    chk("R11 mem_we", mem_we, 0);
    chk("R11 mem_re", mem_re, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    scen = "R4";  drive(8'h08, 8'h08, 1, 8'h00); settle(14);
    scen = "R1";  drive(8'h02, 8'h04, 1, 8'h00); drive(8'hF0, 8'h0F, 1, 8'h00); settle(6);
    scen = "R2";  drive(8'h10, 8'hFF, 1, 8'h08); drive(8'hFF, 8'hFF, 1, 8'hFF); settle(6);
    scen = "R3";  drive(8'h20, 8'h20, 0, 8'h00); settle(4);
                  drive(8'h20, 8'h20, 1, 8'hF7); settle(14);
    scen = "R6";  drive(8'hA4, 8'hFF, 1, 8'h05); settle(14);
    scen = "R7";  drive(8'h80, 8'h80, 1, 8'h00);
                  drive(8'hFF, 8'hFF, 0, 8'h00); settle(14);
    scen = "R8";  drive(8'h01, 8'h01, 1, 8'h00); settle(14);
                  drive(8'h80, 8'hC0, 1, 8'h02); settle(14);
    scen = "R10"; drive(8'h40, 8'h40, 1, 8'h00);
                  repeat (30) @(negedge clk);
                  settle(14);
    scen = "R5";  drive(8'h04, 8'h04, 1, 8'hF7); settle(14);

    @(negedge clk);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule